// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst into a memory array. When a new access starts, the load pulse captures the whole external address. The two least significant bits are the starting offset inside an aligned four-word block. Each later advance cycle steps that offset to the next beat. The upper address bits keep the value captured at the load for the whole burst.

A static order input chooses the stepping rule. Held high, the offset is the start offset XOR the beat count (interleaved order). Held low, the offset is the start offset plus the beat count, wrapping inside the four-word block (linear order). Board strapping should hold the order input high when it is not driven, so interleaved order is the default. Strobe decoding and chip-enable qualification happen upstream: the block receives a load pulse that is already qualified and an active-low advance input.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next value of `addr_o` is all zeros.
- R2: A rising edge with `load_i` high sets `addr_o` to `addr_i` on that edge, whatever `adv_n_i` is.
- R3: With `order_i` low (linear), each advance sets the low two bits of `addr_o` to (start offset + beat count) mod 4. Each step is therefore the previous offset plus one, wrapping from 3 to 0.
- R4: With `order_i` high (interleaved), each advance sets the low two bits of `addr_o` to start offset XOR beat count. The beat count is the number of advances since the load, taken mod 4.
- R5: The offset advances only at an edge where `adv_n_i` is 0 and `load_i` is 0. When `load_i` is 0 and `adv_n_i` is 1, `addr_o` holds its value.
- R6: The upper address bits `addr_o[ADDR_W-1:2]` change only at a load.
- R7: After four advances the low bits are back at the start offset, and further advances repeat the same four-beat sequence.
- R8: A load in the middle of a burst sets the beat count back to zero. Later advances then count from the newly loaded offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Qualified start of a new access; captures `addr_i` |
| adv_n_i | input | 1 | Advance to the next beat, active low |
| order_i | input | 1 | Burst order: 1 = interleaved (strapped default), 0 = linear |
| addr_i | input | ADDR_W | External address sampled at a load |
| addr_o | output | ADDR_W | Registered array address |

## Verification
Every result comes from one register stage. A load, an advance, a hold or a reset sampled at one rising edge shows up on `addr_o` right after that same edge. The bench applies its inputs, waits for exactly one rising edge, updates its reference model for that edge, and compares a quarter period later. Inputs change only after that comparison, so each vector lines up with exactly one edge. The burst order is changed only on load cycles, which keeps one order in force for a whole burst. This holds in both the directed wrap and reload cases and in the seeded random run.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    ORD_LINEAR  = 1'b0,
    ORD_INTERLV = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] start_i,
  input  logic [OFS_W-1:0] beat_i,
  input  burst_order_e     order_i,
  output logic [OFS_W-1:0] ofs_o
);

  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] ilv_ofs;

  // one bit slice per offset bit for the interleaved form
  for (genvar b = 0; b < OFS_W; b++) begin : g_ilv
    assign ilv_ofs[b] = start_i[b] ^ beat_i[b];
  end

  // modular add wraps inside the aligned block
  assign lin_ofs = start_i + beat_i;

  always_comb begin
    unique case (order_i)
      ORD_LINEAR:  ofs_o = lin_ofs;
      ORD_INTERLV: ofs_o = ilv_ofs;
      default:     ofs_o = ilv_ofs;
    endcase
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             adv_n_i,
  input  logic [OFS_W-1:0] start_i,
  output logic [OFS_W-1:0] start_nxt_o,
  output logic [OFS_W-1:0] beat_nxt_o
);

  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;
  logic             step;

  assign step = !load_i && !adv_n_i;

  always_comb begin
    start_nxt_o = start_q;
    beat_nxt_o  = beat_q;
    if (load_i) begin
      start_nxt_o = start_i;
      beat_nxt_o  = '0;
    end else if (step) begin
      beat_nxt_o  = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else begin
      start_q <= start_nxt_o;
      beat_q  <= beat_nxt_o;
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              adv_n_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int OFS_W = $clog2(BURST_LEN);
  localparam int UP_W  = ADDR_W - OFS_W;

  logic [OFS_W-1:0] start_nxt;
  logic [OFS_W-1:0] beat_nxt;
  logic [OFS_W-1:0] ofs_nxt;
  logic [UP_W-1:0]  upper_q;
  logic [OFS_W-1:0] ofs_q;
  burst_order_e     order;

  assign order = burst_order_e'(order_i);

  burst_beat_ctr #(.OFS_W(OFS_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .adv_n_i    (adv_n_i),
    .start_i    (addr_i[OFS_W-1:0]),
    .start_nxt_o(start_nxt),
    .beat_nxt_o (beat_nxt)
  );

  burst_offset_map #(.OFS_W(OFS_W)) u_map (
    .start_i(start_nxt),
    .beat_i (beat_nxt),
    .order_i(order),
    .ofs_o  (ofs_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      ofs_q   <= '0;
    end else begin
      if (load_i) upper_q <= addr_i[ADDR_W-1:OFS_W];
      ofs_q <= ofs_nxt;
    end
  end

  assign addr_o = {upper_q, ofs_q};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic              adv_n_i,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o
);

  // R2: load captures the external address
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> addr_o == $past(addr_i));

  // R5: no advance and no load means hold
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_n_i) |=> $stable(addr_o));

  // R6: upper bits change only at a load
  p_upper_r6: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));

  // R3: linear step is +1 mod 4
  p_linear_r3: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && !order_i) |=>
      addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1));

  // R4: interleaved advance always moves the offset
  p_interleave_r4: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && order_i) |=> addr_o[1:0] != $past(addr_o[1:0]));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .load_i (load_i),
  .adv_n_i(adv_n_i),
  .order_i(order_i),
  .addr_i (addr_i),
  .addr_o (addr_o)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 18;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load_i = 1'b0;
  logic              adv_n_i = 1'b1;
  logic              order_i = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] addr_o;

  int n_vec = 0;
  int n_bad = 0;

  // reference model state
  logic [ADDR_W-3:0] m_upper = '0;
  logic [1:0]        m_start = '0;
  logic [1:0]        m_beat  = '0;
  logic [1:0]        m_ofs   = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BURST_LEN(4)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .load_i(load_i), .adv_n_i(adv_n_i),
    .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o)
  );

  function automatic logic [1:0] ref_ofs(logic [1:0] s, logic [1:0] b, logic ord);
    if (ord) return s ^ b;
    return 2'(s + b);
  endfunction

  task automatic check(string req);
    logic [ADDR_W-1:0] exp;
    exp = {m_upper, m_ofs};
    n_vec++;
    if (addr_o !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  // apply one vector across one rising edge, update the model, compare
  task automatic step(logic ld, logic advn, logic ord, logic [ADDR_W-1:0] a, string req);
    load_i = ld; adv_n_i = advn; order_i = ord; addr_i = a;
    @(posedge clk);
    if (rst) begin
      m_upper = '0; m_start = '0; m_beat = '0; m_ofs = '0;
    end else if (ld) begin
      m_upper = a[ADDR_W-1:2]; m_start = a[1:0]; m_beat = '0;
      m_ofs = a[1:0];
    end else if (!advn) begin
      m_beat = m_beat + 2'd1;
      m_ofs = ref_ofs(m_start, m_beat, ord);
    end
    #(CLK_PERIOD/4);
    check(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic cur_ord;
    void'($urandom(32'h1234_5678));
    // R1 reset state
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b1, 18'h3FFFF, "R1");
    step(1'b0, 1'b1, 1'b1, 18'h3FFFF, "R1");
    rst = 1'b0;

    // R2, R3, R7 linear from offset 1
    step(1'b1, 1'b1, 1'b0, 18'h2A5C1, "R2");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 18'h0, "R3");
    step(1'b0, 1'b0, 1'b0, 18'h0, "R7");   // back at start + 1 after wrap
    // R5 hold with advance idle
    step(1'b0, 1'b1, 1'b0, 18'h11111, "R5");
    step(1'b0, 1'b1, 1'b0, 18'h22222, "R6");

    // R4, R7 interleaved from offset 2 (2,3,0,1,2)
    step(1'b1, 1'b0, 1'b1, 18'h15552, "R2");  // load wins over advance
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 18'h0, "R4");
    step(1'b0, 1'b0, 1'b1, 18'h0, "R7");

    // R8 reload mid-burst
    step(1'b1, 1'b1, 1'b1, 18'h0ABC3, "R8");
    step(1'b0, 1'b0, 1'b1, 18'h0, "R8");
    step(1'b1, 1'b1, 1'b1, 18'h30001, "R8");
    step(1'b0, 1'b0, 1'b1, 18'h0, "R8");
    step(1'b0, 1'b0, 1'b1, 18'h0, "R4");

    // R1 reset mid-burst
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b1, 18'h0, "R1");
    rst = 1'b0;

    // constrained random; order only changes on a load
    cur_ord = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      logic ld, advn;
      logic [ADDR_W-1:0] a;
      ld   = ($urandom % 6) == 0;
      advn = ($urandom % 3) == 0;
      a    = ADDR_W'($urandom);
      if (ld) cur_ord = 1'($urandom);
      step(ld, advn, cur_ord, a,
           ld ? "R2" : (advn ? "R5" : (cur_ord ? "R4" : "R3")));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule